// File: doc/BRIEF.md
# Multi-Queue Transmit Descriptor Queue Reader

This block drains a set of transmit queues that host software fills in a shared memory. All queues sit back to back in one contiguous region. Each queue is a ring of 32-bit entries, and the host marks an entry as new by setting its valid bit. The reader polls the active queues in either fixed-priority or round-robin order and fetches the entry at each queue's read index. When the entry is valid, the reader decodes it into a word-aligned descriptor-chain byte pointer and a flag that says whether the new chain goes at the head or the tail of the connection's existing chain. The decoded entry is offered on a valid/ready output. Once the entry is accepted, the reader writes it back to memory with the valid bit cleared and advances the queue's read index, wrapping at the queue size.

The host cannot read the reader's indices directly. To let it avoid overrunning a ring, the reader copies a queue's read index to a host-chosen memory word each time that queue has consumed a programmed number of entries. One interval setting applies to every queue. The region base, ring size, service order and interval are static settings that are written before the queue count. Writing the queue count clears all per-queue state.

Top module: `txq_reader`

## Requirements
- R1: While reset is held and on the first cycle after it, `mem_req` and `out_valid` are low.
- R2: The byte address of entry `i` of queue `q` is `base*128 + (q*S + i)*4`, where `S = 64 << size_code` is the ring size. `base` is config register 0, and `size_code` is bits 2:0 of config register 1, with values above 6 treated as 6. A memory request keeps its address stable until `mem_ack`.
- R3: In an entry word, bits 20:0 hold descriptor address bits 22:2, so `out_ptr = {word[20:0], 2'b00}`. Bit 30 is the head-placement flag and appears on `out_head` (1 = insert at the head, 0 = append at the tail). Bit 29 is the internal search flag and has no effect on any output.
- R4: Only an entry whose bit 31 is 1 is presented. When the entry at a queue's read index has bit 31 = 0, the reader moves on to poll the next queue and leaves that queue's index unchanged.
- R5: After an entry is accepted (`out_valid && out_ready`), the reader writes that entry back to the same address with bit 31 cleared and every other bit unchanged.
- R6: Each accepted entry advances its queue's read index by one, modulo the ring size S.
- R7: The interval is bits 15:8 of config register 1. When it is N > 0, each queue's read index (zero-extended to 32 bits) is written to that queue's write-back address after every N accepted entries. When N = 0, no write-back occurs. Config register 8+q sets queue q's write-back byte address.
- R8: With bit 3 of config register 1 at 0 (fixed priority), polling restarts at queue 0 after every accepted entry.
- R9: With bit 3 of config register 1 at 1 (round-robin), polling continues at the queue after the one just served, wrapping at the active queue count.
- R10: Writing the queue count (config register 2, clamped to the number of queues) resets every read index, write-back counter and write-back address to 0 and restarts polling at queue 0. A count of 0 leaves the memory port idle.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_queue`, `out_ptr` and `out_head` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in this cycle |
| mem_rdata | input | 32 | Memory read data |
| out_valid | output | 1 | Decoded entry available |
| out_ready | input | 1 | Consumer accepts the decoded entry |
| out_queue | output | 2 | Queue the entry came from |
| out_ptr | output | 23 | Descriptor-chain byte pointer |
| out_head | output | 1 | 1 = link at chain head, 0 = link at tail |

## Verification
The bench loads the same uneven fill pattern (three, one, two and zero entries in four queues) under fixed-priority order and then under round-robin order. The two delivery sequences differ, which separates the two arbitration rules and shows that empty queues are skipped. Entry words alternate the head flag and the search flag, and every pointer field is unique, so a wrong field extraction or a wrong address in the ring shows up as a mismatched pointer or as an entry that was not cleared. A single queue is then filled completely and refilled past its end with an interval of four. This exercises the index wrap and lets the bench compare the write-back word against the exact count at intermediate points and after the wrap.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int ADDR_W   = 24;
    localparam int BASE_W   = ADDR_W - 7;
    localparam int IDX_W    = 12;
    localparam int PTR_W    = 23;
    localparam int IVL_W    = 8;
    localparam int CODE_W   = 3;
    localparam int MIN_LOG  = 6;
    localparam int MAX_CODE = 6;

    localparam int BIT_VALID = 31;
    localparam int BIT_HEAD  = 30;
    localparam int BIT_SRCH  = 29;
    localparam int FLD_W     = PTR_W - 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_OUT,
        ST_CLR,
        ST_WB
    } txq_state_e;

    typedef struct packed {
        logic             head;
        logic [PTR_W-1:0] ptr;
    } txq_dec_t;

    function automatic int unsigned eff_code(input logic [CODE_W-1:0] code);
        return (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
    endfunction

    function automatic logic [IDX_W-1:0] size_mask(input logic [CODE_W-1:0] code);
        logic [31:0] full;
        full = (32'd1 << (MIN_LOG + eff_code(code))) - 32'd1;
        return full[IDX_W-1:0];
    endfunction

    function automatic logic [ADDR_W-1:0] entry_addr(
        input logic [BASE_W-1:0] base,
        input int unsigned       q,
        input logic [CODE_W-1:0] code,
        input logic [IDX_W-1:0]  idx
    );
        logic [31:0] off;
        off = ((32'(q) << (MIN_LOG + eff_code(code))) + 32'(idx)) << 2;
        return {base, 7'b0} + off[ADDR_W-1:0];
    endfunction

    function automatic txq_dec_t decode_entry(input logic [31:0] w);
        txq_dec_t d;
        d.head = w[BIT_HEAD];
        d.ptr  = {w[FLD_W-1:0], 2'b00};
        return d;
    endfunction

    function automatic int unsigned next_q(input int unsigned q, input int unsigned n);
        return (q + 1 >= n) ? 0 : q + 1;
    endfunction

endpackage

// File: rtl/txq_cfg.sv
module txq_cfg
    import txq_pkg::*;
#(
    parameter int NQ = 4,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int CW = $clog2(NQ + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [BASE_W-1:0] base,
    output logic [CODE_W-1:0] code,
    output logic              rr_mode,
    output logic [IVL_W-1:0]  interval,
    output logic [CW-1:0]     qcount,
    output logic              count_wr,
    output logic              wb_we,
    output logic [QW-1:0]     wb_q,
    output logic [ADDR_W-1:0] wb_data
);

    assign count_wr = cfg_we && (cfg_addr == 4'd2);
    assign wb_we    = cfg_we && cfg_addr[3] && (int'(cfg_addr[2:0]) < NQ);
    assign wb_q     = QW'(cfg_addr[2:0]);
    assign wb_data  = cfg_wdata[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            base     <= '0;
            code     <= '0;
            rr_mode  <= 1'b0;
            interval <= '0;
            qcount   <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                4'd0: base <= cfg_wdata[BASE_W-1:0];
                4'd1: begin
                    code     <= cfg_wdata[CODE_W-1:0];
                    rr_mode  <= cfg_wdata[3];
                    interval <= cfg_wdata[8 +: IVL_W];
                end
                4'd2: qcount <= (cfg_wdata > 32'(NQ)) ? CW'(NQ) : cfg_wdata[CW-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/txq_qstate.sv
module txq_qstate
    import txq_pkg::*;
#(
    parameter int NQ = 4,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  logic                         wb_we,
    input  logic [QW-1:0]                wb_q,
    input  logic [ADDR_W-1:0]            wb_data,
    input  logic                         adv,
    input  logic [QW-1:0]                sel_q,
    input  logic [IDX_W-1:0]             mask,
    input  logic [IVL_W-1:0]             interval,
    output logic [NQ-1:0][IDX_W-1:0]     rd_idx,
    output logic [NQ-1:0][ADDR_W-1:0]    wb_addr,
    output logic                         due
);

    logic [NQ-1:0] due_vec;

    for (genvar g = 0; g < NQ; g++) begin : g_q
        logic [IVL_W-1:0] cnt;
        logic             hit;

        assign hit        = adv && (int'(sel_q) == g);
        assign due_vec[g] = (interval != '0) && ((cnt + 1'b1) == interval);

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                rd_idx[g]  <= '0;
                wb_addr[g] <= '0;
                cnt        <= '0;
            end else begin
                if (wb_we && (int'(wb_q) == g)) wb_addr[g] <= wb_data;
                if (hit) begin
                    rd_idx[g] <= (rd_idx[g] + 1'b1) & mask;
                    cnt       <= due_vec[g] ? '0 : cnt + 1'b1;
                end
            end
        end

        // R6: an index never leaves the ring
        assert_idx_range_R6: assert property (@(posedge clk) disable iff (rst)
            (rd_idx[g] & ~mask) == '0);
    end

    assign due = due_vec[sel_q];

endmodule

// File: rtl/txq_reader.sv
module txq_reader
    import txq_pkg::*;
#(
    parameter int NQ = 4,
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int CW = $clog2(NQ + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [QW-1:0]     out_queue,
    output logic [PTR_W-1:0]  out_ptr,
    output logic              out_head
);

    logic [BASE_W-1:0] base;
    logic [CODE_W-1:0] code;
    logic              rr_mode;
    logic [IVL_W-1:0]  interval;
    logic [CW-1:0]     qcount;
    logic              count_wr;
    logic              wb_we;
    logic [QW-1:0]     wb_q;
    logic [ADDR_W-1:0] wb_data;

    txq_cfg #(.NQ(NQ)) i_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .base(base), .code(code), .rr_mode(rr_mode), .interval(interval), .qcount(qcount),
        .count_wr(count_wr), .wb_we(wb_we), .wb_q(wb_q), .wb_data(wb_data)
    );

    txq_state_e                  state;
    logic [QW-1:0]               cur_q;
    logic [31:0]                 ent;
    logic                        adv;
    logic                        due;
    logic [IDX_W-1:0]            mask;
    logic [NQ-1:0][IDX_W-1:0]    rd_idx;
    logic [NQ-1:0][ADDR_W-1:0]   wb_addr;
    logic [ADDR_W-1:0]           ent_addr;
    logic [QW-1:0]               q_after;
    logic [QW-1:0]               q_served;
    txq_dec_t                    dec;

    assign mask = size_mask(code);

    txq_qstate #(.NQ(NQ)) i_qstate (
        .clk(clk), .rst(rst), .clr(count_wr),
        .wb_we(wb_we), .wb_q(wb_q), .wb_data(wb_data),
        .adv(adv), .sel_q(cur_q), .mask(mask), .interval(interval),
        .rd_idx(rd_idx), .wb_addr(wb_addr), .due(due)
    );

    assign ent_addr = entry_addr(base, int'(cur_q), code, rd_idx[cur_q]);
    assign q_after  = QW'(next_q(int'(cur_q), int'(qcount)));
    assign q_served = rr_mode ? q_after : '0;
    assign adv      = (state == ST_CLR) && mem_ack;
    assign dec      = decode_entry(ent);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ent_addr;
        mem_wdata = '0;
        case (state)
            ST_RD:  mem_req = 1'b1;
            ST_CLR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = ent & ~(32'd1 << BIT_VALID);
            end
            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wb_addr[cur_q];
                mem_wdata = 32'(rd_idx[cur_q]);
            end
            default: ;
        endcase
    end

    assign out_valid = (state == ST_OUT);
    assign out_queue = cur_q;
    assign out_ptr   = dec.ptr;
    assign out_head  = dec.head;

    always_ff @(posedge clk) begin
        if (rst || count_wr) begin
            state <= ST_IDLE;
            cur_q <= '0;
            ent   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (qcount != '0) state <= ST_RD;
                ST_RD: if (mem_ack) begin
                    ent <= mem_rdata;
                    if (mem_rdata[BIT_VALID]) state <= ST_OUT;
                    else                      cur_q <= q_after;
                end
                ST_OUT: if (out_ready) state <= ST_CLR;
                ST_CLR: if (mem_ack) begin
                    if (due) state <= ST_WB;
                    else begin
                        state <= ST_RD;
                        cur_q <= q_served;
                    end
                end
                ST_WB: if (mem_ack) begin
                    state <= ST_RD;
                    cur_q <= q_served;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11: a presented entry stays put until taken
    assert_out_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !count_wr) |=> (out_valid && $stable(out_ptr)
            && $stable(out_head) && $stable(out_queue)));

    // R2: an unacknowledged request keeps its address
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !count_wr) |=> (mem_req && $stable(mem_addr)));

    // R5: the write that follows a handshake carries a cleared valid bit
    assert_clear_after_take_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && !count_wr) |=> (mem_req && mem_we && !mem_wdata[BIT_VALID]));

    // R10: with no active queue the memory port stays quiet
    assert_idle_port_R10: assert property (@(posedge clk) disable iff (rst)
        (qcount == '0) |-> !mem_req);

    // R9: the polled queue is always one of the active ones
    assert_queue_range_R9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> (int'(cur_q) < int'(qcount)));

endmodule

// File: tb/test_txq_reader.sv
module test_txq_reader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [1:0]  out_queue;
    logic [22:0] out_ptr;
    logic        out_head;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [31:0] mem [0:1023];

    always #5 clk = ~clk;

    txq_reader i_txq_reader (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
        .out_queue(out_queue), .out_ptr(out_ptr), .out_head(out_head)
    );

    always @(posedge clk) begin
        if (rst) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[11:2]];
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        end else mem_ack <= 1'b0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired: actual=%0d expected<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic ck(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // base field 2 -> byte 256 -> word 64; ring size 64
    function automatic int qw(input int q, input int i);
        return 64 + q * 64 + i;
    endfunction

    function automatic logic [20:0] fld(input int q, input int i, input int gen);
        return 21'(32'h1000 + q * 256 + i + gen * 32'h4000);
    endfunction

    function automatic logic [31:0] mk(input int q, input int i, input int gen);
        logic [31:0] w;
        w = {11'b0, fld(q, i, gen)};
        w[31] = 1'b1;
        w[30] = 1'((q + i + gen) & 1);
        w[29] = 1'(i & 1);
        return w;
    endfunction

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic expect_entry(input int q, input int i, input int gen, input string tag, input bit hold);
        int n = 0;
        logic [22:0] eptr;
        eptr = {fld(q, i, gen), 2'b00};
        while (!out_valid && n < 2000) begin
            @(negedge clk);
            n++;
        end
        ck(out_valid, {tag, " valid"}, longint'(out_valid), 1);
        ck(out_queue == 2'(q), {tag, " queue"}, longint'(out_queue), q);
        ck(out_ptr == eptr, {tag, " R3 R2 ptr"}, longint'(out_ptr), longint'(eptr));
        ck(out_head == 1'((q + i + gen) & 1), {tag, " R3 head"}, longint'(out_head), (q + i + gen) & 1);
        if (hold) begin
            repeat (3) @(negedge clk);
            ck(out_valid && out_ptr == eptr, "R11 hold while not ready", longint'(out_ptr), longint'(eptr));
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic fill_mix(input int gen);
        for (int i = 0; i < 3; i++) mem[qw(0, i)] = mk(0, i, gen);
        mem[qw(1, 0)] = mk(1, 0, gen);
        for (int i = 0; i < 2; i++) mem[qw(2, i)] = mk(2, i, gen);
    endtask

    task automatic check_cleared(input int gen, input string tag);
        for (int i = 0; i < 3; i++)
            ck(mem[qw(0, i)] == (mk(0, i, gen) & 32'h7fffffff), tag, mem[qw(0, i)], mk(0, i, gen) & 32'h7fffffff);
        ck(mem[qw(1, 0)] == (mk(1, 0, gen) & 32'h7fffffff), tag, mem[qw(1, 0)], mk(1, 0, gen) & 32'h7fffffff);
        for (int i = 0; i < 2; i++)
            ck(mem[qw(2, i)] == (mk(2, i, gen) & 32'h7fffffff), tag, mem[qw(2, i)], mk(2, i, gen) & 32'h7fffffff);
    endtask

    initial begin
        int reqs;
        for (int k = 0; k < 1024; k++) mem[k] = '0;
        for (int k = 512; k < 516; k++) mem[k] = 32'hDEAD;
        repeat (3) @(negedge clk);
        ck(!mem_req && !out_valid, "R1 idle in reset", longint'({mem_req, out_valid}), 0);
        rst = 1'b0;
        @(negedge clk);
        ck(!mem_req && !out_valid, "R1 idle after reset", longint'({mem_req, out_valid}), 0);

        // R10: no active queue -> no traffic
        reqs = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (mem_req) reqs++;
        end
        ck(reqs == 0, "R10 count zero idle", reqs, 0);

        // fixed priority, interval 0
        cfg_write(4'd0, 32'd2);
        cfg_write(4'd1, 32'h0000_0000);
        fill_mix(0);
        cfg_write(4'd2, 32'd4);
        for (int q = 0; q < 4; q++) cfg_write(4'(8 + q), 32'h800 + 32'(q * 4));
        expect_entry(0, 0, 0, "R8 fixed #1", 1'b1);
        expect_entry(0, 1, 0, "R8 fixed #2", 1'b0);
        expect_entry(0, 2, 0, "R8 fixed #3", 1'b0);
        expect_entry(1, 0, 0, "R8 fixed #4", 1'b0);
        expect_entry(2, 0, 0, "R8 fixed #5", 1'b0);
        expect_entry(2, 1, 0, "R8 fixed #6", 1'b0);
        repeat (40) @(negedge clk);
        ck(!out_valid, "R4 empty rings present nothing", longint'(out_valid), 0);
        check_cleared(0, "R5 entry cleared");
        for (int q = 0; q < 4; q++)
            ck(mem[512 + q] == 32'hDEAD, "R7 interval zero no write-back", mem[512 + q], 32'hDEAD);

        // round-robin; count rewrite restarts indices at 0
        cfg_write(4'd2, 32'd0);
        fill_mix(1);
        cfg_write(4'd1, 32'h0000_0008);
        cfg_write(4'd2, 32'd4);
        expect_entry(0, 0, 1, "R9 R10 rr #1", 1'b0);
        expect_entry(1, 0, 1, "R9 rr #2", 1'b0);
        expect_entry(2, 0, 1, "R9 rr #3", 1'b0);
        expect_entry(0, 1, 1, "R9 rr #4", 1'b0);
        expect_entry(2, 1, 1, "R9 rr #5", 1'b0);
        expect_entry(0, 2, 1, "R9 rr #6", 1'b0);
        repeat (40) @(negedge clk);
        check_cleared(1, "R5 rr entry cleared");

        // full ring, wrap and periodic write-back every 4
        cfg_write(4'd2, 32'd0);
        mem[513] = 32'hDEAD;
        for (int i = 0; i < 64; i++) mem[qw(1, i)] = mk(1, i, 2);
        cfg_write(4'd1, 32'h0000_0400);
        cfg_write(4'd2, 32'd2);
        cfg_write(4'd9, 32'h804);
        for (int i = 0; i < 64; i++) begin
            if (i == 8 || i == 12)
                begin
                    while (!out_valid) @(negedge clk);
                    ck(mem[513] == 32'(i), "R7 write-back index", mem[513], i);
                end
            expect_entry(1, i, 2, "R6 R2 ring entry", 1'b0);
        end
        mem[qw(1, 0)] = mk(1, 0, 3);
        mem[qw(1, 1)] = mk(1, 1, 3);
        expect_entry(1, 0, 3, "R6 wrap slot 0", 1'b0);
        expect_entry(1, 1, 3, "R6 wrap slot 1", 1'b0);
        repeat (40) @(negedge clk);
        ck(mem[513] == 32'd0, "R7 write-back after wrap", mem[513], 0);
        ck(mem[512] == 32'hDEAD, "R7 idle queue no write-back", mem[512], 32'hDEAD);
        ck(mem[qw(1, 1)] == (mk(1, 1, 3) & 32'h7fffffff), "R5 wrap entry cleared",
           mem[qw(1, 1)], mk(1, 1, 3) & 32'h7fffffff);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule